// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns host requests into bus cycles on an 8-bit asynchronous NAND flash interface. Every request arrives on one valid/ready channel and carries an operation code and a 32-bit word. Four operation codes start a bus cycle: command latch, address latch, data write and data read. Three operation codes update internal state instead: the timing word, the configuration word, and the control word that triggers a soft reset.

Each bus cycle runs through a setup phase, a strobe phase and a hold phase. The lengths come from a timing word that has one set of fields for reads and another for writes. After the hold phase comes an optional ready-sample delay. The sequencer then waits until the synchronized ready/busy pin reads ready, and only after that does it accept the next request. A read returns its captured byte on a response strobe that has no back-pressure.

The back-pressure rules are as follows:
- `req_ready` is high only while the sequencer is idle.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The host may hold `req_valid` for as long as it likes and may change nothing while it waits.
- `rsp_valid` is a single-cycle pulse. It cannot be stalled.

Top module: `nandseq_top`

## Requirements
- R1: After reset the block is in this state:
  - `nand_ce_n`, `nand_we_n` and `nand_re_n` are high.
  - `nand_cle`, `nand_ale`, `nand_dq_oe`, `busy` and `rsp_valid` are low.
  - `req_ready` is high.
  - The timing word and the configuration word are zero.
- R2: The timing word has eight 4-bit fields, and a field value n gives a phase of n+1 clocks. The fields are:
  - Read set: setup in [3:0], hold in [7:4], strobe width in [11:8], ready delay in [15:12].
  - Write set: setup in [19:16], hold in [23:20], strobe width in [27:24], ready delay in [31:28].
  - Each bus cycle is setup, then strobe (`nand_we_n` or `nand_re_n` low), then hold. Reads use the read set and all other cycles use the write set.
- R3: A command request (`req_op` = 0) runs a write cycle in which `nand_cle` is high, `nand_ale` is low and `nand_dq_oe` is high for setup, strobe and hold. `nand_dq_out` carries `req_data[7:0]`.
- R4: An address request (`req_op` = 1) runs the same cycle with `nand_ale` high and `nand_cle` low.
- R5: A data-write request (`req_op` = 2) runs a write cycle with `nand_cle` and `nand_ale` both low. `nand_dq_out` carries `req_data[7:0]`.
- R6: A data-read request (`req_op` = 3) works as follows:
  - It drops `nand_re_n` for the strobe phase, with `nand_dq_oe` low.
  - It captures `nand_dq_in` on the last strobe clock.
  - It pulses `rsp_valid` for one cycle, in the cycle right after the hold phase ends.
  - `rsp_data` is the captured byte zero-extended to 32 bits.
- R7: If the ready-delay field n is nonzero, the block waits 2*n clocks after the hold phase. It then stays busy until the synchronized ready pin reads 1.
- R8: A configuration write (`req_op` = 5) with bit 0 set holds `nand_ce_n` low in every cycle, including idle ones. While that bit is clear, `nand_ce_n` is low only in setup, strobe and hold.
- R9: A control write (`req_op` = 6) with bit 0 set clears the configuration word, which releases `nand_ce_n` high. The timing word written by `req_op` = 4 stays as it was.
- R10: `dev_rdy` follows `nand_rb` through two flops, so a change on the pin shows up after the second clock edge.
- R11: A request is taken only when `busy` is low. A request held during a busy cycle is taken on the first idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this edge if valid |
| req_op | input | 3 | Operation code: 0 cmd, 1 addr, 2 data write, 3 data read, 4 timing, 5 config, 6 control |
| req_data | input | 32 | Request word |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 32 | Zero-extended read byte |
| busy | output | 1 | Sequencer not idle |
| dev_rdy | output | 1 | Synchronized ready/busy pin, 1 = ready |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data in |
| nand_rb | input | 1 | Device ready/busy pin |

## Verification
The embedded assertions check the following on every cycle:
- The two strobes never overlap.
- `nand_cle` and `nand_ale` are never high together.
- Chip enable is low whenever a strobe is low.
- No strobe is low while a request can be taken.
- A strobe phase is entered only from setup.
- A response pulse only ever follows the hold phase of a read.

Some behaviour can only be shown by the bench scenarios, which compare the block against a behavioural model on every clock:
- The exact phase lengths for each timing field.
- The 2*n ready delay and the stall on a busy device.
- The byte captured on a read.
- The effect of the forced chip enable and of the soft reset.
- A request held across a busy cycle.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;
  typedef enum logic [2:0] {
    OP_CMD    = 3'd0,
    OP_ADDR   = 3'd1,
    OP_DWR    = 3'd2,
    OP_DRD    = 3'd3,
    OP_TIMING = 3'd4,
    OP_CFG    = 3'd5,
    OP_CTRL   = 3'd6,
    OP_NONE   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_WAIT   = 3'd4,
    PH_RDY    = 3'd5
  } phase_e;

  // One half of the timing word; the first member is the most significant.
  typedef struct packed {
    logic [3:0] rdy_dly;
    logic [3:0] width;
    logic [3:0] hold;
    logic [3:0] setup;
  } tset_t;

  function automatic logic is_bus_op(op_e op);
    return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_DWR) || (op == OP_DRD);
  endfunction
endpackage

// File: rtl/nandseq_sync.sv
module nandseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/nandseq_regs.sv
module nandseq_regs
  import nandseq_pkg::*;
#(
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  op_e           wr_op,
  input  logic [HW-1:0] wr_data,
  output tset_t         tim_rd,
  output tset_t         tim_wr,
  output logic          force_ce
);
  localparam int TSW = $bits(tset_t);

  logic [2*TSW-1:0] timing_q;
  logic             force_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      force_q  <= 1'b0;
    end else if (wr_en) begin
      unique case (wr_op)
        OP_TIMING: timing_q <= wr_data[2*TSW-1:0];
        OP_CFG:    force_q  <= wr_data[0];
        OP_CTRL:   if (wr_data[0]) force_q <= 1'b0;
        default:   ;
      endcase
    end
  end

  assign tim_rd   = timing_q[TSW-1:0];
  assign tim_wr   = timing_q[2*TSW-1:TSW];
  assign force_ce = force_q;
endmodule

// File: rtl/nandseq_engine.sv
module nandseq_engine
  import nandseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  op_e           op_i,
  input  logic [DW-1:0] byte_i,
  input  tset_t         tim_rd,
  input  tset_t         tim_wr,
  input  logic          force_ce,
  input  logic          rb_s,
  input  logic [DW-1:0] dq_in,
  output logic          idle,
  output logic          rsp_valid,
  output logic [DW-1:0] rd_byte,
  output logic          ce_n,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  localparam int CW = FW + 1;

  phase_e        phase;
  op_e           op_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] byte_q, rd_q;
  logic          rsp_q;
  tset_t         t;
  logic          last, is_rd, in_cyc;

  assign is_rd = (op_q == OP_DRD);
  assign t     = is_rd ? tim_rd : tim_wr;
  assign last  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      op_q   <= OP_NONE;
      cnt    <= '0;
      byte_q <= '0;
      rd_q   <= '0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SETUP;
          op_q   <= op_i;
          byte_q <= byte_i;
          cnt    <= CW'((op_i == OP_DRD) ? tim_rd.setup : tim_wr.setup);
        end
        PH_SETUP: if (last) begin
          phase <= PH_STROBE;
          cnt   <= CW'(t.width);
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (last) begin
          if (is_rd) rd_q <= dq_in;
          phase <= PH_HOLD;
          cnt   <= CW'(t.hold);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (last) begin
          rsp_q <= is_rd;
          if (t.rdy_dly == '0) phase <= PH_RDY;
          else begin
            phase <= PH_WAIT;
            cnt   <= {t.rdy_dly, 1'b0} - CW'(1);
          end
        end else cnt <= cnt - 1'b1;
        PH_WAIT: if (last) phase <= PH_RDY;
                 else      cnt   <= cnt - 1'b1;
        PH_RDY:  if (rb_s) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign in_cyc    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign idle      = (phase == PH_IDLE);
  assign ce_n      = !(force_ce || in_cyc);
  assign cle       = in_cyc && (op_q == OP_CMD);
  assign ale       = in_cyc && (op_q == OP_ADDR);
  assign we_n      = !((phase == PH_STROBE) && !is_rd);
  assign re_n      = !((phase == PH_STROBE) && is_rd);
  assign dq_oe     = in_cyc && !is_rd;
  assign dq_out    = byte_q;
  assign rsp_valid = rsp_q;
  assign rd_byte   = rd_q;

  a_r2_strobe_from_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> $past(phase) == PH_SETUP);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r6_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(phase) == PH_HOLD && $past(op_q) == OP_DRD));
  a_r8_ce_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);
  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (we_n && re_n && !dq_oe));
endmodule

// File: rtl/nandseq_top.sv
module nandseq_top
  import nandseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 4,
  parameter int HW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [HW-1:0] req_data,
  output logic          rsp_valid,
  output logic [HW-1:0] rsp_data,
  output logic          busy,
  output logic          dev_rdy,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_dq_out,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_in,
  input  logic          nand_rb
);
  op_e           op;
  logic          idle, accept, force_ce, rb_s;
  tset_t         tim_rd, tim_wr;
  logic [DW-1:0] rd_byte;

  assign op     = op_e'(req_op);
  assign accept = req_valid && idle;

  nandseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_s)
  );

  nandseq_regs #(.HW(HW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_op(op), .wr_data(req_data),
    .tim_rd(tim_rd), .tim_wr(tim_wr), .force_ce(force_ce)
  );

  nandseq_engine #(.DW(DW), .FW(FW)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(accept && is_bus_op(op)), .op_i(op),
    .byte_i(req_data[DW-1:0]), .tim_rd(tim_rd), .tim_wr(tim_wr),
    .force_ce(force_ce), .rb_s(rb_s), .dq_in(nand_dq_in), .idle(idle),
    .rsp_valid(rsp_valid), .rd_byte(rd_byte), .ce_n(nand_ce_n),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_out(nand_dq_out), .dq_oe(nand_dq_oe)
  );

  assign req_ready = idle;
  assign busy      = !idle;
  assign dev_rdy   = rb_s;
  assign rsp_data  = {{(HW-DW){1'b0}}, rd_byte};
endmodule

// File: tb/sim_nandseq_top.sv
module sim_nandseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [2:0]  req_op = 0;
  logic [31:0] req_data = 0;
  logic [7:0]  nand_dq_in = 0;
  logic        nand_rb = 1;
  logic        req_ready, rsp_valid, busy, dev_rdy;
  logic [31:0] rsp_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;

  int vecs = 0, fails = 0, cyc = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nandseq_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .dev_rdy(dev_rdy), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb)
  );

  // Behavioural reference model: phase 0 idle, 1 setup, 2 strobe, 3 hold, 4 delay, 5 ready wait
  int m_ph, m_op, m_cnt, m_byte, m_rd, m_rsp, m_force, m_sync0, m_sync1;
  logic [31:0] m_tim;

  function automatic int fld(logic [31:0] w, int op, int idx);
    int base = (op == 3) ? 0 : 16;
    return int'((w >> (base + 4*idx)) & 32'hF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_op = 7; m_cnt = 0; m_byte = 0; m_rd = 0; m_rsp = 0;
      m_force = 0; m_sync0 = 0; m_sync1 = 0; m_tim = 0;
    end else begin
      m_rsp = 0;
      case (m_ph)
        0: if (req_valid) begin
          case (int'(req_op))
            0, 1, 2, 3: begin
              m_ph = 1; m_op = int'(req_op); m_byte = int'(req_data[7:0]);
              m_cnt = fld(m_tim, m_op, 0);
            end
            4: m_tim = req_data;
            5: m_force = int'(req_data[0]);
            6: if (req_data[0]) m_force = 0;
            default: ;
          endcase
        end
        1: if (m_cnt == 0) begin m_ph = 2; m_cnt = fld(m_tim, m_op, 2); end else m_cnt--;
        2: if (m_cnt == 0) begin
             if (m_op == 3) m_rd = int'(nand_dq_in);
             m_ph = 3; m_cnt = fld(m_tim, m_op, 1);
           end else m_cnt--;
        3: if (m_cnt == 0) begin
             m_rsp = (m_op == 3);
             if (fld(m_tim, m_op, 3) == 0) m_ph = 5;
             else begin m_ph = 4; m_cnt = 2*fld(m_tim, m_op, 3) - 1; end
           end else m_cnt--;
        4: if (m_cnt == 0) m_ph = 5; else m_cnt--;
        5: if (m_sync1 != 0) m_ph = 0;
        default: m_ph = 0;
      endcase
      m_sync1 = m_sync0;
      m_sync0 = int'(nand_rb);
    end
  end

  task automatic cmp(input int act, input int exp, input string tag);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      automatic bit cyc_on = (m_ph >= 1 && m_ph <= 3);
      cmp(int'(req_ready), int'(m_ph == 0), "R11 req_ready");
      cmp(int'(busy), int'(m_ph != 0), "R11 busy");
      cmp(int'(nand_ce_n), int'(!(m_force != 0 || cyc_on)), "R8 ce_n");
      cmp(int'(nand_cle), int'(cyc_on && m_op == 0), "R3 cle");
      cmp(int'(nand_ale), int'(cyc_on && m_op == 1), "R4 ale");
      cmp(int'(nand_we_n), int'(!(m_ph == 2 && m_op != 3)), "R2 we_n");
      cmp(int'(nand_re_n), int'(!(m_ph == 2 && m_op == 3)), "R6 re_n");
      cmp(int'(nand_dq_oe), int'(cyc_on && m_op != 3), "R5 dq_oe");
      if (cyc_on && m_op != 3) cmp(int'(nand_dq_out), m_byte, "R5 dq_out");
      cmp(int'(rsp_valid), m_rsp, "R6 rsp_valid");
      if (m_rsp != 0) cmp(int'(rsp_data), m_rd, "R6 rsp_data");
      cmp(int'(dev_rdy), m_sync1, "R10 dev_rdy");
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic issue(input int op, input logic [31:0] d);
    wait_idle();
    req_valid = 1; req_op = 3'(op); req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp(int'(nand_ce_n & nand_we_n & nand_re_n), 1, "R1 strobes high");
    cmp(int'(nand_cle | nand_ale | nand_dq_oe | busy | rsp_valid), 0, "R1 controls low");
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    cmp(int'(req_ready), 1, "R1 ready");

    // R3, R4 with all-zero timing: one clock per phase
    issue(0, 32'h0000_01A5);
    issue(1, 32'h0000_003C);
    // R2: distinct read and write field values
    issue(4, 32'h2021_0312);
    issue(2, 32'h0000_0077);             // R5
    nand_dq_in = 8'hC3;
    issue(3, 32'h0);                     // R6
    wait_idle();
    nand_dq_in = 8'h5A;
    issue(3, 32'h0);
    // R7: delay of 2*2 clocks, then stall on busy device
    wait_idle();
    nand_rb = 0;
    repeat (2) @(negedge clk);
    issue(0, 32'h0000_0070);
    repeat (12) @(negedge clk);
    cmp(int'(busy), 1, "R7 busy while device busy");
    nand_rb = 1;
    wait_idle();
    // R10: synchronizer latency
    nand_rb = 0;
    @(negedge clk);
    cmp(int'(dev_rdy), 1, "R10 one edge");
    @(negedge clk);
    cmp(int'(dev_rdy), 0, "R10 two edges");
    nand_rb = 1;
    repeat (2) @(negedge clk);
    // R8: forced chip enable
    issue(5, 32'h1);
    @(negedge clk);
    cmp(int'(nand_ce_n), 0, "R8 forced low idle");
    issue(1, 32'h0000_00E1);
    wait_idle();
    cmp(int'(nand_ce_n), 0, "R8 forced low after cycle");
    // R9: soft reset clears config, timing kept
    issue(6, 32'h1);
    @(negedge clk);
    cmp(int'(nand_ce_n), 1, "R9 ce released");
    issue(2, 32'h0000_0042);
    // R11: request held during busy cycle
    req_valid = 1; req_op = 3'd5; req_data = 32'h1;
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 0;
    cmp(int'(nand_ce_n), 0, "R11 held request taken");
    issue(6, 32'h1);
    issue(4, 32'h0000_0000);
    issue(2, 32'h0000_0099);
    wait_idle();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule